// File: doc/BRIEF.md
# HDLC Frame Receiver

This block turns a synchronous serial bit stream into frame bytes. A bit is taken on each clock edge where the bit enable is high. The receiver searches the line for flag patterns and removes the zero bits the transmitter inserted for transparency. It then packs the remaining bits into bytes, least significant bit first. Bytes between an opening and a closing flag form one frame. They leave the block as one-cycle beats on a valid/data/last output, and the final beat comes with a frame status code.

Every frame is assumed to end with a two-byte frame check sequence. The receiver holds each byte back by two bytes, so the check sequence is never emitted as data, and the flags are removed as well. The check sequence can be verified against the 16-bit CCITT residue. A run of seven ones inside a frame aborts it, and the receiver returns to flag search. An optional filter drops every frame whose first (address) byte differs from a configured value. The receiver runs from a register enable, optionally gated by a carrier-detect input.

Top module: `hdlcRx`

## Requirements
- R1: While the receiver is off (`cfgRxEnable` low, or the carrier gate below closed), input bits are ignored, no beat or status is produced, and a frame in progress is discarded; after turning on, the receiver waits for a new opening flag.
- R2: When `cfgAutoDcd` is high, the receiver is on only while both `dcd` and `cfgRxEnable` are high; when it is low, `dcd` has no effect.
- R3: Only cycles with `bitEn` high consume a line bit; the value of `rxBit` on other cycles has no effect, and output pulses appear only on the edge after an enabled bit.
- R4: A flag is a 0, six 1s and a 0. Flags delimit frames. Repeated flags, and flags that share their boundary zero, produce no status and no beats.
- R5: A 0 that follows five consecutive 1s inside a frame is removed before byte assembly, so payload bytes such as 0xFF and 0x7E come out unchanged.
- R6: Frame bytes are assembled LSB first. All bytes except the final two are emitted in order, and the final emitted byte has `outLast` high with `statValid` high in the same cycle.
- R7: Status codes on `statCode`: 1 good, 2 check-sequence error, 3 alignment error, 4 short frame, 5 abort. With `cfgCrcCheck` high, an aligned frame of at least three bytes is good only if the 16-bit reflected CCITT CRC (polynomial 0x8408, preset 0xFFFF) run over all its bytes, including the check sequence, leaves 0xF0B8; otherwise it gets code 2. With `cfgCrcCheck` low, no check is made.
- R8: A frame whose destuffed bit count between the flags is not a multiple of eight ends with code 3; this code takes priority over codes 4 and 2.
- R9: An aligned frame of one or two bytes ends with code 4 and emits no beat; a frame with no complete byte produces nothing.
- R10: Seven consecutive 1s after an opening flag abort the frame: if at least one byte was assembled, a status with code 5 is given without `outLast`, and the receiver searches for the next flag. Idle ones after a closing flag produce no status.
- R11: With `cfgAddrFilter` high, a frame whose first byte differs from `cfgAddr` produces no beat and no status; matching frames pass unchanged.
- R12: After reset, and between events, `outValid`, `outLast` and `statValid` are low; each beat and each status lasts exactly one cycle, and a beat without `outLast` never carries a status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Line bit present this cycle |
| rxBit | input | 1 | Serial line bit |
| cfgRxEnable | input | 1 | Receiver enable |
| cfgAutoDcd | input | 1 | Gate receiver with `dcd` |
| dcd | input | 1 | Carrier detect |
| cfgCrcCheck | input | 1 | Verify the frame check sequence |
| cfgAddrFilter | input | 1 | Drop frames with a different first byte |
| cfgAddr | input | 8 | Address compared with the first byte |
| outValid | output | 1 | Frame byte beat |
| outData | output | 8 | Frame byte |
| outLast | output | 1 | Final byte of the frame |
| statValid | output | 1 | Frame status pulse |
| statCode | output | 3 | Frame status code |

## Verification
The bench builds the receiver with its default parameters: a stuffing run of five ones, a 16-bit check sequence and therefore a three-byte hold. With these settings, a sweep over every payload length from one to twelve bytes covers both the shortest good frame and frames that fill the hold several times over. Those payloads carry 0xFF and 0x7E bytes, so destuffing and false flags are exercised. The bench computes the check sequence itself and checks that corrupt, misaligned, short, aborted, filtered and disabled frames each get their own outcome. Spare cycles with `bitEn` low carry inverted bits on the line, which checks that bits on those cycles are ignored.

// File: rtl/hdlcRxPkg.sv
package hdlcRxPkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_NONE    = 3'd0,
    ST_OK      = 3'd1,
    ST_CRC_BAD = 3'd2,
    ST_ALIGN   = 3'd3,
    ST_SHORT   = 3'd4,
    ST_ABORT   = 3'd5
  } rxStatus_e;

  typedef enum logic {
    RX_HUNT  = 1'b0,
    RX_FRAME = 1'b1
  } rxState_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic      shiftEn;
    logic      bitVal;
    logic      byteDone;
    logic      openFrame;
    logic      emitMid;
    logic      emitLast;
    logic      statValid;
    rxStatus_e statCode;
  } rxStrobe_t;

endpackage

// File: rtl/hdlcRxCtrl.sv
module hdlcRxCtrl
  import hdlcRxPkg::*;
#(
  parameter int STUFF_RUN  = 5,
  parameter int HOLD_DEPTH = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      rxBit,
  input  logic      rxOn,
  input  logic      filterEn,
  input  logic      crcCheckEn,
  input  logic      addrMatch,
  input  logic      crcGood,
  output rxStrobe_t stb
);

  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int RUN_W     = $clog2(ABORT_RUN + 1);
  localparam int BIT_W     = $clog2(BYTE_W);
  localparam int HELD_W    = $clog2(HOLD_DEPTH + 1);
  // flag bits already shifted in when the closing zero arrives: leading 0 plus the stuff run
  localparam int FLAG_TAIL = STUFF_RUN + 1;

  rxState_e          state;
  logic [RUN_W-1:0]  runCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [HELD_W-1:0] heldCnt;

  logic [RUN_W-1:0]  runNext;
  logic              isFlag;
  logic              isStuff;
  logic              isAbort;
  logic              isData;
  logic              dropNow;
  logic              inFrame;

  assign inFrame = (state == RX_FRAME);

  always_comb begin
    if (!rxBit)                                 runNext = '0;
    else if (runCnt == RUN_W'(ABORT_RUN))       runNext = runCnt;
    else                                        runNext = runCnt + 1'b1;
  end

  assign isFlag  = bitEn && !rxBit && (runCnt == RUN_W'(FLAG_RUN));
  assign isStuff = bitEn && !rxBit && (runCnt == RUN_W'(STUFF_RUN));
  assign isAbort = bitEn &&  rxBit && (runCnt == RUN_W'(FLAG_RUN));
  assign isData  = bitEn && !isFlag && !isStuff
                   && !(rxBit && (runCnt >= RUN_W'(STUFF_RUN)));

  always_comb begin
    stb     = '0;
    dropNow = 1'b0;
    if (rxOn) begin
      if (isFlag) begin
        stb.openFrame = 1'b1;
        if (inFrame && (heldCnt != '0)) begin
          stb.statValid = 1'b1;
          stb.emitLast  = (heldCnt == HELD_W'(HOLD_DEPTH));
          if (bitCnt != BIT_W'(FLAG_TAIL))              stb.statCode = ST_ALIGN;
          else if (heldCnt < HELD_W'(HOLD_DEPTH))       stb.statCode = ST_SHORT;
          else if (crcCheckEn && !crcGood)              stb.statCode = ST_CRC_BAD;
          else                                          stb.statCode = ST_OK;
        end
      end else if (isAbort) begin
        if (inFrame && (heldCnt != '0)) begin
          stb.statValid = 1'b1;
          stb.statCode  = ST_ABORT;
        end
      end else if (isData && inFrame) begin
        stb.shiftEn  = 1'b1;
        stb.bitVal   = rxBit;
        stb.byteDone = (bitCnt == BIT_W'(BYTE_W - 1));
        if (stb.byteDone) begin
          dropNow     = filterEn && (heldCnt == '0) && !addrMatch;
          stb.emitMid = (heldCnt == HELD_W'(HOLD_DEPTH));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_HUNT;
      runCnt  <= '0;
      bitCnt  <= '0;
      heldCnt <= '0;
    end else if (!rxOn) begin
      state   <= RX_HUNT;
      runCnt  <= '0;
      bitCnt  <= '0;
      heldCnt <= '0;
    end else if (bitEn) begin
      runCnt <= runNext;
      if (isFlag) begin
        state   <= RX_FRAME;
        bitCnt  <= '0;
        heldCnt <= '0;
      end else if (isAbort) begin
        state <= RX_HUNT;
      end else if (stb.shiftEn) begin
        if (stb.byteDone) begin
          bitCnt <= '0;
          if (dropNow)                                state   <= RX_HUNT;
          else if (heldCnt != HELD_W'(HOLD_DEPTH))    heldCnt <= heldCnt + 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hdlcRxDp.sv
module hdlcRxDp
  import hdlcRxPkg::*;
#(
  parameter int          CRC_W       = 16,
  parameter logic [15:0] CRC_POLY    = 16'h8408,
  parameter logic [15:0] CRC_INIT    = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8,
  parameter int          HOLD_DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic [BYTE_W-1:0] cfgAddr,
  output logic              addrMatch,
  output logic              crcGood,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outLast,
  output logic              statValid,
  output rxStatus_e         statCode
);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] newByte;
  logic [CRC_W-1:0]  crcReg;
  logic [BYTE_W-1:0] hold [HOLD_DEPTH];

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] cIn,
                                               input logic [BYTE_W-1:0] dIn);
    logic [CRC_W-1:0] r;
    r = cIn;
    for (int k = 0; k < BYTE_W; k++) begin
      if (r[0] ^ dIn[k]) r = (r >> 1) ^ CRC_POLY[CRC_W-1:0];
      else               r = r >> 1;
    end
    return r;
  endfunction

  assign newByte   = {stb.bitVal, shiftReg[BYTE_W-1:1]};
  assign addrMatch = (newByte == cfgAddr);
  assign crcGood   = (crcReg == CRC_RESIDUE[CRC_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      crcReg   <= CRC_INIT[CRC_W-1:0];
    end else begin
      if (stb.shiftEn) shiftReg <= newByte;
      if (stb.openFrame)     crcReg <= CRC_INIT[CRC_W-1:0];
      else if (stb.byteDone) crcReg <= crcStep(crcReg, newByte);
    end
  end

  // byte hold line: newest at the top, oldest at index 0
  for (genvar i = 0; i < HOLD_DEPTH; i++) begin : g_hold
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hold[i] <= '0;
      end else if (stb.byteDone) begin
        if (i == HOLD_DEPTH - 1) hold[i] <= newByte;
        else                     hold[i] <= hold[(i + 1) % HOLD_DEPTH];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outLast   <= 1'b0;
      statValid <= 1'b0;
      statCode  <= ST_NONE;
    end else begin
      outValid  <= stb.emitMid || stb.emitLast;
      outLast   <= stb.emitLast;
      statValid <= stb.statValid;
      statCode  <= stb.statValid ? stb.statCode : ST_NONE;
      if (stb.emitMid || stb.emitLast) outData <= hold[0];
    end
  end

endmodule

// File: rtl/hdlcRx.sv
module hdlcRx
  import hdlcRxPkg::*;
#(
  parameter int          STUFF_RUN   = 5,
  parameter int          CRC_W       = 16,
  parameter logic [15:0] CRC_POLY    = 16'h8408,
  parameter logic [15:0] CRC_INIT    = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       rxBit,
  input  logic       cfgRxEnable,
  input  logic       cfgAutoDcd,
  input  logic       dcd,
  input  logic       cfgCrcCheck,
  input  logic       cfgAddrFilter,
  input  logic [7:0] cfgAddr,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outLast,
  output logic       statValid,
  output logic [2:0] statCode
);

  localparam int FCS_BYTES  = CRC_W / BYTE_W;
  localparam int HOLD_DEPTH = FCS_BYTES + 1;

  rxStrobe_t stb;
  rxStatus_e dpStatCode;
  logic      rxOn;
  logic      addrMatch;
  logic      crcGood;

  assign rxOn = cfgRxEnable && (!cfgAutoDcd || dcd);

  hdlcRxCtrl #(
    .STUFF_RUN (STUFF_RUN),
    .HOLD_DEPTH(HOLD_DEPTH)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .rxBit     (rxBit),
    .rxOn      (rxOn),
    .filterEn  (cfgAddrFilter),
    .crcCheckEn(cfgCrcCheck),
    .addrMatch (addrMatch),
    .crcGood   (crcGood),
    .stb       (stb)
  );

  hdlcRxDp #(
    .CRC_W      (CRC_W),
    .CRC_POLY   (CRC_POLY),
    .CRC_INIT   (CRC_INIT),
    .CRC_RESIDUE(CRC_RESIDUE),
    .HOLD_DEPTH (HOLD_DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cfgAddr  (cfgAddr),
    .addrMatch(addrMatch),
    .crcGood  (crcGood),
    .outValid (outValid),
    .outData  (outData),
    .outLast  (outLast),
    .statValid(statValid),
    .statCode (dpStatCode)
  );

  assign statCode = dpStatCode;

endmodule

// File: rtl/hdlcRxChk.sv
module hdlcRxChk
  import hdlcRxPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic       cfgRxEnable,
  input logic       cfgAutoDcd,
  input logic       dcd,
  input logic       outValid,
  input logic       outLast,
  input logic       statValid,
  input logic [2:0] statCode
);

  // R6
  last_needs_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R6
  last_has_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> (statValid && (statCode == ST_OK || statCode == ST_CRC_BAD
                                             || statCode == ST_ALIGN)));

  // R12
  mid_beat_no_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |-> !statValid);

  // R1
  off_is_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgRxEnable && (!cfgAutoDcd || dcd)) |=> (!outValid && !statValid));

  // R3
  no_bit_no_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> (!outValid && !statValid));

  // R9
  short_has_no_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && statCode == ST_SHORT) |-> !outValid);

  // R10
  abort_has_no_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && statCode == ST_ABORT) |-> !outLast);

  // R7
  code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> (statCode >= 3'd1 && statCode <= 3'd5));

endmodule

bind hdlcRx hdlcRxChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bitEn      (bitEn),
  .cfgRxEnable(cfgRxEnable),
  .cfgAutoDcd (cfgAutoDcd),
  .dcd        (dcd),
  .outValid   (outValid),
  .outLast    (outLast),
  .statValid  (statValid),
  .statCode   (statCode)
);

// File: tb/hdlcRx_tb.sv
module hdlcRx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_BUF    = 32;
  localparam int MAX_REC    = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       rxBit = 1'b1;
  logic       cfgRxEnable = 1'b0;
  logic       cfgAutoDcd = 1'b0;
  logic       dcd = 1'b0;
  logic       cfgCrcCheck = 1'b1;
  logic       cfgAddrFilter = 1'b0;
  logic [7:0] cfgAddr = 8'h00;
  logic       outValid;
  logic [7:0] outData;
  logic       outLast;
  logic       statValid;
  logic [2:0] statCode;

  hdlcRx u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit),
    .cfgRxEnable(cfgRxEnable), .cfgAutoDcd(cfgAutoDcd), .dcd(dcd),
    .cfgCrcCheck(cfgCrcCheck), .cfgAddrFilter(cfgAddrFilter), .cfgAddr(cfgAddr),
    .outValid(outValid), .outData(outData), .outLast(outLast),
    .statValid(statValid), .statCode(statCode)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int runOnes = 0;
  int gapExtra = 0;
  logic [7:0] txBuf [MAX_BUF];
  logic [7:0] recData [MAX_REC];
  logic       recLast [MAX_REC];
  int recCnt = 0;
  int stCnt = 0;
  int okCnt = 0;
  int lastCode = 0;
  logic lastCodeWithData = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (recCnt < MAX_REC) begin
          recData[recCnt] = outData;
          recLast[recCnt] = outLast;
        end
        recCnt++;
      end
      if (statValid) begin
        stCnt++;
        lastCode = int'(statCode);
        lastCodeWithData = outValid && outLast;
        if (statCode == 3'd1) okCnt++;
      end
    end
  end

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fcsOf(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[0] ^ txBuf[i][k];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return ~c;
  endfunction

  // one line bit, followed by idle-enable cycles carrying the inverted bit
  task automatic sendRaw(input logic b);
    @(negedge clk);
    rxBit = b;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    rxBit = ~b;
    repeat (gapExtra) @(negedge clk);
  endtask

  task automatic sendDataBit(input logic b);
    sendRaw(b);
    if (b) begin
      runOnes++;
      if (runOnes == 5) begin
        sendRaw(1'b0);
        runOnes = 0;
      end
    end else begin
      runOnes = 0;
    end
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int k = 0; k < 8; k++) sendDataBit(v[k]);
  endtask

  task automatic sendFlag();
    sendRaw(1'b0);
    repeat (6) sendRaw(1'b1);
    sendRaw(1'b0);
    runOnes = 0;
  endtask

  task automatic sendIdle(input int n);
    repeat (n) sendRaw(1'b1);
    runOnes = 0;
  endtask

  task automatic sendBody(input int n, input bit corrupt);
    logic [15:0] fcs;
    fcs = fcsOf(n);
    if (corrupt) fcs = fcs ^ 16'h0010;
    for (int i = 0; i < n; i++) sendByte(txBuf[i]);
    sendByte(fcs[7:0]);
    sendByte(fcs[15:8]);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic clearRec();
    recCnt = 0;
    stCnt = 0;
    okCnt = 0;
    lastCode = 0;
    lastCodeWithData = 1'b0;
  endtask

  task automatic fillBuf(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      if (i % 4 == 2)      txBuf[i] = 8'hFF;
      else if (i % 5 == 3) txBuf[i] = 8'h7E;
      else                 txBuf[i] = 8'((seed * 29 + i * 71 + 163) % 256);
    end
  endtask

  task automatic checkPayload(input string req, input int n);
    int bad;
    bad = 0;
    chkEq(req, "beat count", recCnt, n);
    for (int i = 0; i < n && i < MAX_REC; i++) begin
      if (recData[i] != txBuf[i]) bad++;
      if (recLast[i] != (i == n - 1)) bad++;
    end
    chkEq(req, "payload/last mismatches", bad, 0);
  endtask

  task automatic goodFrame(input string req, input int n);
    clearRec();
    sendFlag();
    sendBody(n, 1'b0);
    sendFlag();
    sendIdle(9);
    settle();
    chkEq(req, "status count", stCnt, 1);
    chkEq(req, "status code", lastCode, 1);
    chkEq(req, "status on last beat", int'(lastCodeWithData), 1);
    checkPayload(req, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    chkEq("R12", "reset outValid", int'(outValid), 0);
    chkEq("R12", "reset outLast", int'(outLast), 0);
    chkEq("R12", "reset statValid", int'(statValid), 0);
    rstN = 1'b1;
    cfgRxEnable = 1'b1;
    sendIdle(10);

    // R6 R5 R3: payload length sweep with stuffing-heavy bytes and varied gaps
    for (int len = 1; len <= 12; len++) begin
      gapExtra = len % 3;
      fillBuf(len, len);
      goodFrame("R6", len);
    end
    gapExtra = 0;

    // R3: long gaps with garbage on the line
    gapExtra = 4;
    fillBuf(6, 40);
    goodFrame("R3", 6);
    gapExtra = 0;

    // R7: corrupted check sequence
    fillBuf(5, 50);
    clearRec();
    sendFlag(); sendBody(5, 1'b1); sendFlag(); sendIdle(9); settle();
    chkEq("R7", "bad fcs code", lastCode, 2);
    checkPayload("R7", 5);

    // R7: check disabled, corruption ignored
    cfgCrcCheck = 1'b0;
    clearRec();
    sendFlag(); sendBody(5, 1'b1); sendFlag(); sendIdle(9); settle();
    chkEq("R7", "unchecked code", lastCode, 1);
    cfgCrcCheck = 1'b1;

    // R8: three extra bits before the closing flag
    fillBuf(4, 60);
    clearRec();
    sendFlag(); sendBody(4, 1'b0);
    sendDataBit(1'b1); sendDataBit(1'b0); sendDataBit(1'b1);
    sendFlag(); sendIdle(9); settle();
    chkEq("R8", "status count", stCnt, 1);
    chkEq("R8", "align code", lastCode, 3);

    // R9: two-byte and one-byte frames
    fillBuf(2, 70);
    clearRec();
    sendFlag(); sendByte(txBuf[0]); sendByte(txBuf[1]); sendFlag(); sendIdle(9); settle();
    chkEq("R9", "two-byte code", lastCode, 4);
    chkEq("R9", "two-byte beats", recCnt, 0);
    clearRec();
    sendFlag(); sendByte(txBuf[0]); sendFlag(); sendIdle(9); settle();
    chkEq("R9", "one-byte code", lastCode, 4);
    chkEq("R9", "one-byte beats", recCnt, 0);

    // R10: abort after four bytes, then recovery
    fillBuf(4, 80);
    clearRec();
    sendFlag();
    for (int i = 0; i < 4; i++) sendByte(txBuf[i]);
    sendIdle(9);
    settle();
    chkEq("R10", "abort status count", stCnt, 1);
    chkEq("R10", "abort code", lastCode, 5);
    chkEq("R10", "abort beats", recCnt, 1);
    chkEq("R10", "abort outLast", int'(lastCodeWithData), 0);
    fillBuf(3, 81);
    goodFrame("R10", 3);

    // R4: repeated and shared-zero flags alone
    clearRec();
    sendFlag(); sendFlag(); sendFlag();
    for (int j = 0; j < 3; j++) begin
      repeat (6) sendRaw(1'b1);
      sendRaw(1'b0);
    end
    runOnes = 0;
    sendIdle(9);
    settle();
    chkEq("R4", "flags only status", stCnt, 0);
    chkEq("R4", "flags only beats", recCnt, 0);

    // R4: two frames sharing a flag zero
    clearRec();
    fillBuf(3, 90);
    sendFlag(); sendBody(3, 1'b0); sendFlag();
    repeat (6) sendRaw(1'b1);
    sendRaw(1'b0);
    runOnes = 0;
    fillBuf(2, 91);
    sendBody(2, 1'b0); sendFlag(); sendIdle(9); settle();
    chkEq("R4", "shared flag good frames", okCnt, 2);
    chkEq("R4", "shared flag beats", recCnt, 5);

    // R11: address filter
    cfgAddrFilter = 1'b1;
    cfgAddr = 8'h5C;
    fillBuf(4, 100);
    txBuf[0] = 8'h5C;
    goodFrame("R11", 4);
    txBuf[0] = 8'h3A;
    clearRec();
    sendFlag(); sendBody(4, 1'b0); sendFlag(); sendIdle(9); settle();
    chkEq("R11", "filtered status", stCnt, 0);
    chkEq("R11", "filtered beats", recCnt, 0);
    txBuf[0] = 8'h5C;
    goodFrame("R11", 4);
    cfgAddrFilter = 1'b0;

    // R1: disabled receiver
    cfgRxEnable = 1'b0;
    fillBuf(4, 110);
    clearRec();
    sendFlag(); sendBody(4, 1'b0); sendFlag(); sendIdle(9); settle();
    chkEq("R1", "disabled status", stCnt, 0);
    chkEq("R1", "disabled beats", recCnt, 0);

    // R1: disable in mid-frame discards it
    cfgRxEnable = 1'b1;
    clearRec();
    sendFlag();
    sendByte(txBuf[0]); sendByte(txBuf[1]); sendByte(txBuf[2]);
    cfgRxEnable = 1'b0;
    sendByte(txBuf[3]);
    cfgRxEnable = 1'b1;
    begin
      logic [15:0] f;
      f = fcsOf(4);
      sendByte(f[7:0]); sendByte(f[15:8]);
    end
    sendFlag(); sendIdle(9); settle();
    chkEq("R1", "mid-frame disable status", stCnt, 0);
    chkEq("R1", "mid-frame disable beats", recCnt, 0);
    goodFrame("R1", 4);

    // R2: carrier gate
    cfgAutoDcd = 1'b1;
    dcd = 1'b0;
    clearRec();
    sendFlag(); sendBody(4, 1'b0); sendFlag(); sendIdle(9); settle();
    chkEq("R2", "dcd low status", stCnt, 0);
    dcd = 1'b1;
    goodFrame("R2", 4);
    cfgRxEnable = 1'b0;
    clearRec();
    sendFlag(); sendBody(4, 1'b0); sendFlag(); sendIdle(9); settle();
    chkEq("R2", "dcd high but disabled status", stCnt, 0);
    cfgRxEnable = 1'b1;
    cfgAutoDcd = 1'b0;
    dcd = 1'b0;
    goodFrame("R2", 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule